// File: doc/BRIEF.md
# Clock Reference Activity and Frequency Monitor

This block watches a bank of candidate clock references with a fast, free-running master clock, nominally 12.8 MHz. It checks each reference continuously for activity and for frequency error. Each reference input is a single-bit toggling signal. It first passes through a two-flop synchronizer, and its rising edges are then detected in the master-clock domain. A shared gate counter divides time into windows of a fixed number of master-clock cycles. Each channel counts the rising edges that arrive in a window. At the end of the window the channel subtracts a programmed nominal count from that edge count, which gives a signed frequency offset.

Loss of signal is raised as soon as a channel goes a programmable number of master-clock cycles without a rising edge. It is cleared only at a window boundary, and only after a whole window that had edges and no such silent stretch. The offset flag uses two programmable limits with hysteresis. A reference is rejected when the magnitude of its offset is above the reject limit. It is accepted again only when the magnitude falls below the lower accept limit. A reference counts as qualified when it has neither loss of signal nor an offset alarm. A reference-selection stage downstream uses these qualified flags to decide which inputs may be used.

Top module: `ref_activity_monitor`

## Requirements
- R1: The gate window lasts exactly GATE_CYCLES master-clock cycles. `window_done` is high for one cycle at the start of each new window, so its pulses are GATE_CYCLES cycles apart. The status seen in that cycle is the result of the window that just ended.
- R2: Loss of signal (`los[i]` = 1) is raised without waiting for a window boundary. It rises no more than `los_limit` + 3 cycles after the last rising edge of reference i.
- R3: `los[i]` falls only in a `window_done` cycle. It falls only if the window just ended had at least one edge and no gap of `los_limit` cycles without an edge. If a reference restarts partway through a window after going silent, `los[i]` stays at 1 through the end of that window.
- R4: The offset of a window is the number of rising edges counted in it minus `nominal_count`, taken as a signed value. Its magnitude is what gets compared with the limits.
- R5: At each window end, an offset magnitude greater than `reject_limit` sets `offset_bad[i]` to 1.
- R6: At a window end, `offset_bad[i]` is cleared only when the magnitude is below `accept_limit`. A magnitude between the two limits, inclusive, leaves the flag unchanged.
- R7: `qualified[i]` is 1 exactly when `los[i]` = 0 and `offset_bad[i]` = 0.
- R8: After reset, every `los` bit is 1, every `offset_bad` bit is 0, every `qualified` bit is 0 and `window_done` is 0.
- R9: The NUM_REFS channels are independent. Each has its own synchronizer, counters and status, so the behaviour of one reference never changes the status of another.
- R10: A reference held constant, either high or low, counts zero edges. It is reported with `los` = 1 and, when `nominal_count` is greater than `reject_limit`, with `offset_bad` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NUM_REFS | Reference inputs, one bit per reference |
| nominal_count | input | CNT_W | Expected edge count per window |
| reject_limit | input | CNT_W | Offset magnitude above which a reference is rejected |
| accept_limit | input | CNT_W | Offset magnitude below which a rejected reference is accepted again |
| los_limit | input | CNT_W | Edge-free master-clock cycles that raise loss of signal |
| los | output | NUM_REFS | Loss-of-signal flag for each reference |
| offset_bad | output | NUM_REFS | Frequency-offset alarm for each reference |
| qualified | output | NUM_REFS | Reference usable: neither flag set |
| window_done | output | 1 | One-cycle pulse when status has just been updated |

## Verification
The twelve references are driven at several rates at the same time, chosen relative to the nominal count. One rate is exactly nominal. Some are fast enough to be rejected. One falls inside the hysteresis band, between the two limits. One is slow enough that its edges are farther apart than the loss limit. The remaining inputs are held high or held low. The band rate is applied twice: once after a good history and once after a rejected history. Because the outcome differs between the two, this separates hold behaviour from plain threshold compares. Stopping one reference and restarting it partway through a window tells immediate loss detection apart from the rule that loss clears only after a whole clean window.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    // Synchronizer pipeline: two metastability stages plus the previous-value stage.
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_state_t;

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync
    import refmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    sync_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.stable & ~st_q.prev;

    // An edge pulse can never be two cycles long
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/refmon_gate.sv
module refmon_gate #(
    parameter int GATE_CYCLES = 12800
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end,
    output logic window_done
);
    localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

    typedef struct packed {
        logic [GW-1:0] cnt;
        logic          done;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d      = g_q;
        g_d.cnt  = (g_q.cnt == LAST) ? '0 : g_q.cnt + 1'b1;
        g_d.done = (g_q.cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign gate_end    = (g_q.cnt == LAST);
    assign window_done = g_q.done;

    assert_gate_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.cnt <= LAST);
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        window_done |=> !window_done);

endmodule

// File: rtl/refmon_chan.sv
module refmon_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             gate_end,
    input  logic [CNT_W-1:0] nominal_count,
    input  logic [CNT_W-1:0] reject_limit,
    input  logic [CNT_W-1:0] accept_limit,
    input  logic [CNT_W-1:0] los_limit,
    output logic             los,
    output logic             bad
);
    localparam int W1 = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] edges;
        logic [CNT_W-1:0] sil;
        logic             win_sil;
        logic             los;
        logic             bad;
    } chan_t;

    chan_t c_d, c_q;

    logic [CNT_W-1:0] sil_next;
    logic             hit;
    logic [W1-1:0]    edge_sum;
    logic [CNT_W-1:0] total;
    logic signed [W1-1:0] diff;
    logic [W1-1:0]    mag;

    always_comb begin
        c_d = c_q;

        // Silence counter saturates at the programmed limit
        if (rise)                       sil_next = '0;
        else if (c_q.sil >= los_limit)  sil_next = c_q.sil;
        else                            sil_next = c_q.sil + 1'b1;
        hit = (sil_next >= los_limit);
        c_d.sil = sil_next;

        // Edge count including an edge that lands in the window's last cycle
        edge_sum = {1'b0, c_q.edges} + W1'(rise);
        total    = edge_sum[CNT_W] ? '1 : edge_sum[CNT_W-1:0];

        diff = $signed({1'b0, total}) - $signed({1'b0, nominal_count});
        mag  = (diff < 0) ? W1'(-diff) : W1'(diff);

        if (gate_end) begin
            c_d.edges   = '0;
            c_d.win_sil = 1'b0;
            c_d.los     = c_q.win_sil | hit | (total == '0);
            if (mag > W1'(reject_limit))      c_d.bad = 1'b1;
            else if (mag < W1'(accept_limit)) c_d.bad = 1'b0;
        end else begin
            c_d.edges   = total;
            c_d.win_sil = c_q.win_sil | hit;
            c_d.los     = c_q.los | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.los <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign los = c_q.los;
    assign bad = c_q.bad;

    assert_los_on_silence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> los);
    assert_los_clear_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los) |-> $past(gate_end));
    assert_bad_change_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bad) |-> $past(gate_end));
    assert_reject_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end && mag > W1'(reject_limit)) |=> bad);
    assert_band_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end && mag <= W1'(reject_limit) && mag >= W1'(accept_limit)) |=> $stable(bad));

endmodule

// File: rtl/ref_activity_monitor.sv
module ref_activity_monitor #(
    parameter int NUM_REFS    = 12,
    parameter int CNT_W       = 16,
    parameter int GATE_CYCLES = 12800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_in,
    input  logic [CNT_W-1:0]    nominal_count,
    input  logic [CNT_W-1:0]    reject_limit,
    input  logic [CNT_W-1:0]    accept_limit,
    input  logic [CNT_W-1:0]    los_limit,
    output logic [NUM_REFS-1:0] los,
    output logic [NUM_REFS-1:0] offset_bad,
    output logic [NUM_REFS-1:0] qualified,
    output logic                window_done
);
    logic gate_end;
    logic [NUM_REFS-1:0] rise;

    refmon_gate #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_end(gate_end), .window_done(window_done)
    );

    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ch
        refmon_sync u_sync (
            .clk(clk), .rst_n(rst_n), .async_in(ref_in[i]), .rise(rise[i])
        );
        refmon_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .rise(rise[i]), .gate_end(gate_end),
            .nominal_count(nominal_count), .reject_limit(reject_limit),
            .accept_limit(accept_limit), .los_limit(los_limit),
            .los(los[i]), .bad(offset_bad[i])
        );
    end

    assign qualified = ~los & ~offset_bad;

    // Status is only refreshed at window boundaries, apart from a new loss
    assert_status_moves_at_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(qualified) != qualified) |-> ($past(gate_end) || ($past(los) != los)));

endmodule

// File: tb/ref_activity_monitor_test.sv
module ref_activity_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 12;
    localparam int CW   = 12;
    localparam int GATE = 200;
    localparam int NOM  = 20;
    localparam int REJ  = 4;
    localparam int ACC  = 2;
    localparam int LLIM = 30;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0] refs = '0;
    logic [N-1:0] los, bad, qual;
    logic window_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_activity_monitor #(.NUM_REFS(N), .CNT_W(CW), .GATE_CYCLES(GATE)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(refs),
        .nominal_count(CW'(NOM)), .reject_limit(CW'(REJ)),
        .accept_limit(CW'(ACC)), .los_limit(CW'(LLIM)),
        .los(los), .offset_bad(bad), .qualified(qual), .window_done(window_done)
    );

    int checks = 0;
    int fails  = 0;

    // Per-reference half period in cycles (0 = held at stuck level)
    int half_r [N];
    logic stuck_r [N];
    int cnt_r [N];

    typedef struct {
        logic [N-1:0] los;
        logic [N-1:0] bad;
        string        tag;
    } exp_t;
    exp_t sb[$];
    logic exp_bad [N];

    initial begin
        for (int i = 0; i < N; i++) begin half_r[i] = 0; stuck_r[i] = 0; cnt_r[i] = 0; exp_bad[i] = 0; end
        forever begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if (half_r[i] == 0) refs[i] = stuck_r[i];
                else if (cnt_r[i] >= half_r[i] - 1) begin refs[i] = ~refs[i]; cnt_r[i] = 0; end
                else cnt_r[i] = cnt_r[i] + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_window();
        do @(negedge clk); while (!window_done);
    endtask

    // Driver: apply rates at a window start, settle, push expectation for the third window
    task automatic scenario(input int h [N], input logic s [N], input string tag);
        exp_t e;
        wait_window();
        for (int i = 0; i < N; i++) begin half_r[i] = h[i]; stuck_r[i] = s[i]; end
        wait_window();
        wait_window();
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) begin
            int c;
            int m;
            c = (h[i] == 0) ? 0 : GATE / (2 * h[i]);
            m = (c > NOM) ? c - NOM : NOM - c;
            e.los[i] = (h[i] == 0) || (2 * h[i] - 1 >= LLIM);
            if (m > REJ) exp_bad[i] = 1;
            else if (m < ACC) exp_bad[i] = 0;
            e.bad[i] = exp_bad[i];
        end
        e.tag = tag;
        sb.push_back(e);
        while (sb.size() > 0) @(negedge clk);
    endtask

    // Monitor: compare at each status update while expectations are pending
    always @(negedge clk) begin
        if (rst_n && window_done && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            for (int i = 0; i < N; i++) begin
                check(los[i] == e.los[i], $sformatf("R2/R3/R10 los ref%0d %s", i, e.tag), los[i], e.los[i]);
                check(bad[i] == e.bad[i], $sformatf("R4/R5/R6 bad ref%0d %s", i, e.tag), bad[i], e.bad[i]);
                check(qual[i] == (!e.los[i] && !e.bad[i]), $sformatf("R7 qual ref%0d %s", i, e.tag),
                      qual[i], (!e.los[i] && !e.bad[i]));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int h1 [N] = '{5,5,5,5,5,5,5,5,5,5,5,5};
        int h2 [N] = '{5,4,0,3,20,5,6,5,0,5,4,5};
        int h3 [N] = '{5,6,5,5,20,5,6,5,0,5,4,5};
        int h4 [N] = '{5,5,5,5,20,5,6,5,0,5,4,5};
        logic s0 [N] = '{0,0,0,0,0,0,0,0,0,0,0,0};
        logic s2 [N] = '{0,0,0,0,0,0,0,0,1,0,0,0};
        int gap;

        repeat (4) @(negedge clk);
        // R8 reset state
        check(los == '1, "R8 los reset", los, '1);
        check(bad == '0, "R8 bad reset", bad, 0);
        check(qual == '0, "R8 qual reset", qual, 0);
        check(window_done == 0, "R8 window_done reset", window_done, 0);
        rst_n = 1;

        scenario(h1, s0, "all nominal");
        // R9 R10: mixed rates, stuck low/high, slow ref; ref6 band after good history stays good
        scenario(h2, s2, "mixed");
        // R6: ref1 band after rejection stays bad; ref2/ref3 recover
        scenario(h3, s2, "band hold");
        scenario(h4, s2, "accept");

        // R2: stop ref7 at a window start and see LOS without waiting for the window
        wait_window();
        half_r[7] = 0; stuck_r[7] = 0;
        repeat (LLIM + 5) @(negedge clk);
        check(los[7] == 1, "R2 los raised early", los[7], 1);
        check(window_done == 0, "R2 before window end", window_done, 0);
        // R3: restart within the window, LOS must persist
        half_r[7] = 5;
        repeat (20) @(negedge clk);
        check(los[7] == 1, "R3 los held mid-window", los[7], 1);
        wait_window();
        check(los[7] == 1, "R3 los held after dirty window", los[7], 1);
        wait_window();
        check(los[7] == 0, "R3 los cleared after clean window", los[7], 0);

        // R1: window spacing
        gap = 0;
        do begin @(negedge clk); gap++; end while (!window_done);
        check(gap == GATE, "R1 window period", gap, GATE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule